// File: doc/BRIEF.md
# Channel Register Bank with Interrupt Aggregation

This block is the register file of an eight-channel line interface. A host reaches it over a simple byte-wide read/write strobe bus with a 16-bit address. The high address byte picks a channel, and each channel has its own copy of a control byte, a live status byte, a sticky interrupt byte and an interrupt enable byte. One global control byte, reachable only when the high byte is zero, sets how the channels pick between E1 and T1 line rates.

Event pulses from the line side set interrupt bits. Those bits stay set until the host reads them, and the read clears them. Every pending bit that its enable bit lets through drives one shared active-low interrupt line. Each channel also gets a registered rate-select output. In flexible mode that output follows the channel's own control bit. In fixed mode every channel follows one shared bit.

Top module: `regbank_top`

## Requirements
- R1: Address decode. The high byte `addr[15:8]` equal to a channel number 0..7 selects that channel's registers, at low-byte offsets 0x00 control, 0x01 status, 0x02 interrupt status and 0x03 interrupt enable. High byte 0x00 with low byte 0x80 selects the global control byte. Read data is registered and appears on `rdata` in the cycle after the `rd_en` edge.
- R2: A write to a control or interrupt-enable byte is read back unchanged.
- R3: A status read returns the value of that channel's `stat_in` byte as sampled at the read edge. Writes to status offsets have no effect on what is read.
- R4: An interrupt status bit is set by a one-cycle pulse on the matching `evt_in` bit and holds until read. The read returns the pending value and clears the byte.
- R5: If an event pulse arrives in the same cycle as a clearing read, the affected bit stays set after the read.
- R6: Reset loads every interrupt-enable byte with 0xFF and every channel control byte with 0x00.
- R7: `irq_n` is low one cycle after any interrupt status bit is set together with its enable bit (1 = enabled). Otherwise it is high, and it is high after reset.
- R8: In the global control byte, bit 0 selects flexible mode (1) and bit 1 is the shared T1 select. Reset value is 0x01, so all channels start in E1 with flexible mode on.
- R9: `mode_t1[c]` is 1 for T1 and 0 for E1. It equals bit 0 of channel c's control byte in flexible mode and global bit 1 in fixed mode. It updates one cycle after the register changes.
- R10: A read of an unmapped address returns 0x00. Writes to unmapped addresses, status bytes or interrupt status bytes change nothing.
- R11: A write to one channel's register leaves the other channels' copies unchanged. A high byte of 8 or more does not alias onto channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 16 | Byte address: high byte is channel, low byte is offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| stat_in | input | 64 | Live status, byte c belongs to channel c |
| evt_in | input | 64 | Event pulses, byte c belongs to channel c |
| irq_n | output | 1 | Active-low combined interrupt |
| mode_t1 | output | 8 | Per-channel rate select, 1 = T1 |

## Verification
The assertions assume that `rd_en` and `wr_en` are never both high in one cycle. They also assume that `evt_in` carries single-cycle pulses rather than levels, because a held level would keep re-setting a bit right after it is read. The stimulus drives every strobe and pulse for exactly one cycle and changes inputs away from the sampling edge. Each clear-on-read case is driven once with a coinciding event and once without.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h01;
  localparam logic [7:0] OFS_ISR  = 8'h02;
  localparam logic [7:0] OFS_IMR  = 8'h03;
  localparam logic [7:0] OFS_GCTL = 8'h80;

  localparam int unsigned GCTL_FLEX_BIT = 0;
  localparam int unsigned GCTL_T1_BIT   = 1;
  localparam logic [7:0]  GCTL_RESET    = 8'h01;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_ISR,
    SEL_IMR,
    SEL_GCTL
  } sel_e;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 16,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [AW-1:0]  addr,
  output sel_e           sel,
  output logic [CHW-1:0] ch
);
  logic [AW-9:0] hi;
  logic [7:0]    lo;

  assign hi = addr[AW-1:8];
  assign lo = addr[7:0];
  assign ch = hi[CHW-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (hi < (AW-8)'(NCH)) begin
      case (lo)
        OFS_CTRL: sel = SEL_CTRL;
        OFS_STAT: sel = SEL_STAT;
        OFS_ISR:  sel = SEL_ISR;
        OFS_IMR:  sel = SEL_IMR;
        default:  sel = SEL_NONE;
      endcase
    end
    if (hi == '0 && lo == OFS_GCTL) sel = SEL_GCTL;
  end
endmodule

// File: rtl/regbank_chan.sv
module regbank_chan #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_imr,
  input  logic          rd_isr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] imr_q,
  output logic [DW-1:0] isr_q,
  output logic          pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      imr_q  <= '1;
      isr_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_imr)  imr_q  <= wdata;
      // a coinciding event is ORed in after the clear, so it survives
      isr_q <= (rd_isr ? '0 : isr_q) | evt;
    end
  end

  assign pend = |(isr_q & imr_q);

  assert_mask_reset_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (imr_q == '1 && ctrl_q == '0));

  assert_event_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((isr_q & $past(evt)) == $past(evt)));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_isr |=> ((isr_q & $past(isr_q)) == $past(isr_q)));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_isr && evt == '0) |=> (isr_q == '0));

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_isr && evt != '0) |=> (isr_q == $past(evt)));
endmodule

// File: rtl/regbank_gctl.sv
module regbank_gctl
  import regbank_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] own_t1,
  output logic [DW-1:0]  gctl_q,
  output logic [NCH-1:0] mode_t1
);
  logic [NCH-1:0] mode_nxt;

  always_ff @(posedge clk) begin
    if (rst) gctl_q <= DW'(GCTL_RESET);
    else if (wr) gctl_q <= wdata;
  end

  always_comb begin
    if (gctl_q[GCTL_FLEX_BIT]) mode_nxt = own_t1;
    else                       mode_nxt = {NCH{gctl_q[GCTL_T1_BIT]}};
  end

  always_ff @(posedge clk) begin
    if (rst) mode_t1 <= '0;
    else     mode_t1 <= mode_nxt;
  end

  assert_flex_follows_own_R9: assert property (@(posedge clk) disable iff (rst)
    $past(gctl_q[GCTL_FLEX_BIT]) |-> (mode_t1 == $past(own_t1)));

  assert_fixed_shared_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(gctl_q[GCTL_FLEX_BIT]) |-> (mode_t1 == {NCH{$past(gctl_q[GCTL_T1_BIT])}}));

  assert_reset_e1_flex_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gctl_q[GCTL_FLEX_BIT] && mode_t1 == '0));
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 16,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NCH*DW-1:0] stat_in,
  input  logic [NCH*DW-1:0] evt_in,
  output logic              irq_n,
  output logic [NCH-1:0]    mode_t1
);
  sel_e           sel;
  logic [CHW-1:0] ch;
  logic [DW-1:0]  ctrl_a [NCH];
  logic [DW-1:0]  imr_a  [NCH];
  logic [DW-1:0]  isr_a  [NCH];
  logic [DW-1:0]  stat_a [NCH];
  logic [NCH-1:0] pend_v;
  logic [NCH-1:0] own_t1;
  logic [DW-1:0]  gctl_q;
  logic [DW-1:0]  rd_nxt;

  regbank_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .addr (addr),
    .sel  (sel),
    .ch   (ch)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit       = (ch == CHW'(c));
    assign stat_a[c] = stat_in[c*DW +: DW];
    assign own_t1[c] = ctrl_a[c][0];

    regbank_chan #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_ctrl (wr_en && sel == SEL_CTRL && hit),
      .wr_imr  (wr_en && sel == SEL_IMR && hit),
      .rd_isr  (rd_en && sel == SEL_ISR && hit),
      .wdata   (wdata),
      .evt     (evt_in[c*DW +: DW]),
      .ctrl_q  (ctrl_a[c]),
      .imr_q   (imr_a[c]),
      .isr_q   (isr_a[c]),
      .pend    (pend_v[c])
    );
  end

  regbank_gctl #(.NCH(NCH), .DW(DW)) u_gctl (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_en && sel == SEL_GCTL),
    .wdata   (wdata),
    .own_t1  (own_t1),
    .gctl_q  (gctl_q),
    .mode_t1 (mode_t1)
  );

  always_comb begin
    case (sel)
      SEL_CTRL: rd_nxt = ctrl_a[ch];
      SEL_STAT: rd_nxt = stat_a[ch];
      SEL_ISR:  rd_nxt = isr_a[ch];
      SEL_IMR:  rd_nxt = imr_a[ch];
      SEL_GCTL: rd_nxt = gctl_q;
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq_n <= 1'b1;
    end else begin
      if (rd_en) rdata <= rd_nxt;
      irq_n <= ~|pend_v;
    end
  end

  assert_irq_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == !$past(|pend_v)));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_NONE) |=> (rdata == '0));

  assert_irq_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> irq_n);
endmodule

// File: tb/regbank_top_tb.sv
`timescale 1ns/1ps
module regbank_top_tb;
  localparam int NCH = 8;
  localparam int DW  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rd_en = 1'b0;
  logic              wr_en = 1'b0;
  logic [15:0]       addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic [DW-1:0]     rdata;
  logic [NCH*DW-1:0] stat_in = '0;
  logic [NCH*DW-1:0] evt_in = '0;
  logic              irq_n;
  logic [NCH-1:0]    mode_t1;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  regbank_top #(.NCH(NCH), .DW(DW), .AW(16)) u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .stat_in(stat_in), .evt_in(evt_in),
    .irq_n(irq_n), .mode_t1(mode_t1)
  );

  // fields: req[36:33] op[32] (1=read-check) addr[31:16] data[15:8] exp[7:0]
  localparam int NV = 14;
  localparam logic [36:0] VEC [NV] = '{
    {4'd6,  1'b1, 16'h0000, 8'h00, 8'h00},  // R6 ctrl reset
    {4'd6,  1'b1, 16'h0303, 8'h00, 8'hFF},  // R6 enable reset
    {4'd8,  1'b1, 16'h0080, 8'h00, 8'h01},  // R8 global reset
    {4'd2,  1'b0, 16'h0200, 8'hA5, 8'h00},  // R2 write ctrl ch2
    {4'd2,  1'b1, 16'h0200, 8'h00, 8'hA5},  // R2
    {4'd11, 1'b1, 16'h0100, 8'h00, 8'h00},  // R11 neighbour untouched
    {4'd2,  1'b0, 16'h0503, 8'h3C, 8'h00},  // R2 write enable ch5
    {4'd2,  1'b1, 16'h0503, 8'h00, 8'h3C},  // R2
    {4'd11, 1'b1, 16'h0403, 8'h00, 8'hFF},  // R11
    {4'd10, 1'b1, 16'h0104, 8'h00, 8'h00},  // R10 unmapped offset
    {4'd1,  1'b1, 16'h0180, 8'h00, 8'h00},  // R1 global only at high byte 0
    {4'd10, 1'b0, 16'h0800, 8'hFF, 8'h00},  // R10 write to channel 8
    {4'd11, 1'b1, 16'h0000, 8'h00, 8'h00},  // R11 no alias onto ch0
    {4'd10, 1'b1, 16'h0800, 8'h00, 8'h00}   // R10 channel 8 reads zero
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_evt(input logic [15:0] a, input int c, input logic [DW-1:0] b,
                        output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a; evt_in[c*DW +: DW] = b;
    @(negedge clk);
    rd_en = 1'b0; evt_in = '0;
    d = rdata;
  endtask

  task automatic pulse(input int c, input logic [DW-1:0] b);
    @(negedge clk);
    evt_in[c*DW +: DW] = b;
    @(negedge clk);
    evt_in = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-R act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 irq_n reset", {7'd0, irq_n}, 8'h01);
    check("R8 mode reset E1", mode_t1, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) begin
        do_read(VEC[i][31:16], d);
        check($sformatf("R%0d vector %0d", VEC[i][36:33], i), d, VEC[i][7:0]);
      end else begin
        do_write(VEC[i][31:16], VEC[i][15:8]);
      end
    end

    // R3 status is live and read-only
    stat_in[3*DW +: DW] = 8'h5A;
    do_read(16'h0301, d); check("R3 status", d, 8'h5A);
    do_write(16'h0301, 8'hFF);
    do_read(16'h0301, d); check("R3 status after write", d, 8'h5A);
    stat_in[3*DW +: DW] = 8'h11;
    do_read(16'h0301, d); check("R3 status live", d, 8'h11);

    // R4 sticky and clear on read
    pulse(1, 8'h04);
    pulse(1, 8'h10);
    do_read(16'h0102, d); check("R4 pending", d, 8'h14);
    do_read(16'h0102, d); check("R4 cleared", d, 8'h00);
    pulse(1, 8'h02);
    do_write(16'h0102, 8'h00);
    do_read(16'h0102, d); check("R10 isr write ignored", d, 8'h02);

    // R5 event coinciding with clearing read
    pulse(0, 8'h80);
    rd_evt(16'h0002, 0, 8'h80, d); check("R5 read value", d, 8'h80);
    do_read(16'h0002, d); check("R5 bit survives", d, 8'h80);
    do_read(16'h0002, d); check("R5 then cleared", d, 8'h00);
    @(negedge clk);

    // R7 interrupt combining and masking
    check("R7 idle", {7'd0, irq_n}, 8'h01);
    pulse(6, 8'h01);
    @(negedge clk);
    check("R7 asserted", {7'd0, irq_n}, 8'h00);
    do_read(16'h0602, d);
    @(negedge clk);
    check("R7 released", {7'd0, irq_n}, 8'h01);
    do_write(16'h0603, 8'hFE);
    pulse(6, 8'h01);
    @(negedge clk);
    check("R7 masked", {7'd0, irq_n}, 8'h01);
    do_write(16'h0603, 8'hFF);
    @(negedge clk);
    check("R7 unmasked", {7'd0, irq_n}, 8'h00);
    do_read(16'h0602, d); check("R4 masked bit kept", d, 8'h01);
    @(negedge clk);
    check("R7 released again", {7'd0, irq_n}, 8'h01);

    // R9 mode selection (ch2 ctrl = A5, bit0 = 1)
    check("R9 flexible", mode_t1, 8'h04);
    do_write(16'h0080, 8'h02);
    @(negedge clk);
    check("R9 fixed T1", mode_t1, 8'hFF);
    do_write(16'h0080, 8'h00);
    @(negedge clk);
    check("R9 fixed E1", mode_t1, 8'h00);
    do_write(16'h0080, 8'h01);
    do_write(16'h0700, 8'h01);
    @(negedge clk);
    check("R9 flexible two channels", mode_t1, 8'h84);
    do_read(16'h0080, d); check("R2 global readback", d, 8'h01);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule